// File: doc/BRIEF.md
# Parallel ADC Conversion Sequencer

This block sits on the host side of a parallel successive-approximation converter. It drives the converter's active-low select line and its convert/read strobe, follows the converter's idle flag, and returns one 16-bit result per request. When the block is idle and sees a start request, it issues a conversion pulse. It then waits for the converter to report that it is busy and then idle again. Next it opens a read window, captures the data bus inside that window and presents the result with a one-cycle strobe. Finally it holds off new requests for an acquisition interval.

The parameter `SEL_START` picks how a conversion begins. With `SEL_START = 0` the select line stays low at all times and a low pulse on the convert strobe starts the conversion. With `SEL_START = 1` the convert strobe falls first, a setup interval later the select line falls, and the conversion begins at that point. The block counts every pulse width, setup time, acquisition gap and timeout in system clocks, and each of these counts is a parameter.

A watchdog runs from the start of each conversion. If the converter does not report idle again within the timeout, the block raises an error flag and returns to idle without producing a result.

Top module: `adc_conv_seq`

## Requirements
- R1: After reset the convert strobe `adc_cnv_n_o` is high, `result_vld_o` and `timeout_err_o` are low, and `result_o` is zero. The select line `adc_sel_n_o` is low when SEL_START=0 and high when SEL_START=1.
- R2: With SEL_START=0, a start request taken in idle drives `adc_cnv_n_o` low on the next cycle for exactly T_PULSE cycles. During that pulse `adc_sel_n_o` stays low.
- R3: With SEL_START=1, a start request taken in idle drives `adc_cnv_n_o` low for T_SETUP cycles while `adc_sel_n_o` is high. Both lines are then low together for exactly T_PULSE cycles, after which both return high.
- R4: `adc_cnv_n_o` is never low for more than T_RC_MAX consecutive cycles.
- R5: A start request is ignored while a conversion, read or acquisition interval is under way, and also while `adc_idle_i` is low. An ignored request never causes a new low edge on `adc_cnv_n_o`.
- R6: After the pulse, the block waits until it has seen `adc_idle_i` low and then high. The cycle after that it opens a read window of T_PULSE cycles with `adc_cnv_n_o` high and `adc_sel_n_o` low, and it samples `adc_data_i` only in the last cycle of that window. The strobe therefore rises T_PULSE+1 cycles after `adc_idle_i` returns high.
- R7: Each capture drives `result_o` with the sampled bus value and raises `result_vld_o` for exactly one cycle.
- R8: If `adc_idle_i` has not returned high T_TIMEOUT cycles after the first pulse cycle, `timeout_err_o` rises on the next cycle. The block then returns to idle with the lines in their idle levels and gives no result. The flag clears on the cycle after the next accepted start.
- R9: After `result_vld_o`, a new conversion pulse begins no sooner than T_ACQ+1 cycles later. A start request held high is accepted so that `adc_cnv_n_o` falls exactly T_ACQ+1 cycles after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request one conversion; taken only when idle |
| adc_idle_i | input | 1 | Converter idle flag, low while a conversion runs |
| adc_data_i | input | DATA_W | Converter data bus |
| adc_sel_n_o | output | 1 | Active-low converter select |
| adc_cnv_n_o | output | 1 | Convert/read strobe: low converts, high reads |
| result_o | output | DATA_W | Last captured conversion result |
| result_vld_o | output | 1 | One-cycle strobe marking a new result |
| timeout_err_o | output | 1 | Set on conversion timeout, cleared by the next start |

## Verification
The checker watches on every cycle that the convert strobe stays low no longer than its ceiling, and that overlapping pulses last at least T_PULSE. In select-start mode it also checks that the select line falls only after the setup interval. Further per-cycle checks cover sampling only inside a read window, the strobe rising only after the acquisition gap, a one-cycle valid strobe, and no new pulse while the converter reports busy. Only the bench scenarios can show the exact values: returned data against the converter model, the cycle the error flag rises, the latency from busy release to the strobe, and recovery after a timeout.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_CONV  = 3'd2,
    ST_WAIT  = 3'd3,
    ST_READ  = 3'd4,
    ST_ACQ   = 3'd5
  } seq_st_e;

  // Bits needed to count from zero up to n.
  function automatic int cnt_w(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // True in the final cycle of an interval of len cycles counted from 0.
  function automatic logic last_cyc(input int unsigned cnt, input int unsigned len);
    return cnt == len - 1;
  endfunction

endpackage

// File: rtl/seq_count.sv
module seq_count #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] cnt
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (clr)              cnt <= '0;
    else if (en && cnt != '1)  cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/seq_capture.sv
module seq_capture #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] result_o,
  output logic          vld_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_o <= '0;
      vld_o    <= 1'b0;
    end else begin
      vld_o <= cap;
      if (cap) result_o <= data_i;
    end
  end

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int SEL_START = 0,
  parameter int T_SETUP   = 2,
  parameter int T_PULSE   = 8,
  parameter int T_TIMEOUT = 2000,
  parameter int T_ACQ     = 200,
  parameter int PH_W      = 8,
  parameter int TO_W      = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            idle_i,
  input  logic [PH_W-1:0] ph_cnt,
  input  logic [TO_W-1:0] to_cnt,
  output seq_st_e         st_o,
  output logic            ph_clr_o,
  output logic            conv_active_o,
  output logic            start_accept_o,
  output logic            busy_rise_o,
  output logic            timeout_evt_o,
  output logic            capture_evt_o,
  output logic            err_o
);

  seq_st_e st, nxt;
  logic    seen_low;

  assign start_accept_o = (st == ST_IDLE) && start_i && idle_i;
  assign busy_rise_o    = (st == ST_WAIT) && seen_low && idle_i;
  assign timeout_evt_o  = (st == ST_WAIT) && !busy_rise_o &&
                          last_cyc(32'(to_cnt), T_TIMEOUT);
  assign capture_evt_o  = (st == ST_READ) && last_cyc(32'(ph_cnt), T_PULSE);
  assign conv_active_o  = (st == ST_CONV) || (st == ST_WAIT);
  assign ph_clr_o       = (nxt != st);
  assign st_o           = st;

  always_comb begin
    nxt = st;
    unique case (st)
      ST_IDLE:  if (start_accept_o) nxt = (SEL_START != 0) ? ST_SETUP : ST_CONV;
      ST_SETUP: if (last_cyc(32'(ph_cnt), T_SETUP)) nxt = ST_CONV;
      ST_CONV:  if (last_cyc(32'(ph_cnt), T_PULSE)) nxt = ST_WAIT;
      ST_WAIT: begin
        if (busy_rise_o)        nxt = ST_READ;
        else if (timeout_evt_o) nxt = ST_IDLE;
      end
      ST_READ:  if (capture_evt_o) nxt = ST_ACQ;
      ST_ACQ:   if (last_cyc(32'(ph_cnt), T_ACQ)) nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      seen_low <= 1'b0;
      err_o    <= 1'b0;
    end else begin
      st <= nxt;
      if (start_accept_o)                seen_low <= 1'b0;
      else if (conv_active_o && !idle_i) seen_low <= 1'b1;
      if (timeout_evt_o)                 err_o <= 1'b1;
      else if (start_accept_o)           err_o <= 1'b0;
    end
  end

endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
  import adc_seq_pkg::*;
#(
  parameter int SEL_START = 0,
  parameter int DATA_W    = 16,
  parameter int T_SETUP   = 2,
  parameter int T_PULSE   = 8,
  parameter int T_RC_MAX  = 600,
  parameter int T_TIMEOUT = 2000,
  parameter int T_ACQ     = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              adc_idle_i,
  input  logic [DATA_W-1:0] adc_data_i,
  output logic              adc_sel_n_o,
  output logic              adc_cnv_n_o,
  output logic [DATA_W-1:0] result_o,
  output logic              result_vld_o,
  output logic              timeout_err_o
);

  localparam int PH_W = cnt_w(max3(T_SETUP, T_PULSE, T_ACQ));
  localparam int TO_W = cnt_w(T_TIMEOUT);

  seq_st_e         st;
  logic [PH_W-1:0] ph_cnt;
  logic [TO_W-1:0] to_cnt;
  logic            ph_clr, conv_active;
  logic            start_accept, busy_rise, timeout_evt, capture_evt;

  seq_ctrl #(
    .SEL_START(SEL_START), .T_SETUP(T_SETUP), .T_PULSE(T_PULSE),
    .T_TIMEOUT(T_TIMEOUT), .T_ACQ(T_ACQ), .PH_W(PH_W), .TO_W(TO_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .idle_i(adc_idle_i),
    .ph_cnt(ph_cnt), .to_cnt(to_cnt), .st_o(st), .ph_clr_o(ph_clr),
    .conv_active_o(conv_active), .start_accept_o(start_accept),
    .busy_rise_o(busy_rise), .timeout_evt_o(timeout_evt),
    .capture_evt_o(capture_evt), .err_o(timeout_err_o)
  );

  // Cycles spent in the current state.
  seq_count #(.W(PH_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .clr(ph_clr), .en(1'b1), .cnt(ph_cnt)
  );

  // Cycles since the conversion pulse began.
  seq_count #(.W(TO_W)) u_watch (
    .clk(clk), .rst_n(rst_n), .clr(start_accept), .en(conv_active), .cnt(to_cnt)
  );

  seq_capture #(.DW(DATA_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .cap(capture_evt), .data_i(adc_data_i),
    .result_o(result_o), .vld_o(result_vld_o)
  );

  assign adc_cnv_n_o = !((st == ST_SETUP) || (st == ST_CONV));

  generate
    if (SEL_START != 0) begin : g_sel_start
      assign adc_sel_n_o = !((st == ST_CONV) || (st == ST_READ));
    end else begin : g_strobe_start
      assign adc_sel_n_o = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/adc_conv_seq_chk.sv
module adc_conv_seq_chk #(
  parameter int SEL_START = 0,
  parameter int T_SETUP   = 2,
  parameter int T_PULSE   = 8,
  parameter int T_RC_MAX  = 600,
  parameter int T_ACQ     = 200
) (
  input logic clk,
  input logic rst_n,
  input logic adc_sel_n_o,
  input logic adc_cnv_n_o,
  input logic adc_idle_i,
  input logic result_vld_o,
  input logic timeout_err_o,
  input logic capture_evt
);

  int unsigned low_cnt, both_cnt, since_vld;
  logic        both_q;
  logic        both_now;

  assign both_now = !adc_sel_n_o && !adc_cnv_n_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt   <= 0;
      both_cnt  <= 0;
      both_q    <= 1'b0;
      since_vld <= 32'(T_ACQ + 1);
    end else begin
      if (adc_cnv_n_o)         low_cnt <= 0;
      else if (low_cnt != '1)  low_cnt <= low_cnt + 1;
      if (!both_now)           both_cnt <= 0;
      else if (both_cnt != '1) both_cnt <= both_cnt + 1;
      both_q <= both_now;
      if (result_vld_o)         since_vld <= 0;
      else if (since_vld != '1) since_vld <= since_vld + 1;
    end
  end

  // R4
  cnv_low_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_cnv_n_o |-> low_cnt < T_RC_MAX);

  // R2
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (both_q && !both_now) |-> both_cnt >= T_PULSE);

  // R3
  sel_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((SEL_START != 0) && $fell(adc_sel_n_o) && !adc_cnv_n_o) |-> low_cnt >= T_SETUP);

  // R5
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!adc_idle_i && adc_cnv_n_o) |=> adc_cnv_n_o);

  // R6
  read_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capture_evt |-> adc_cnv_n_o && !adc_sel_n_o);

  // R7
  one_cycle_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    result_vld_o |=> !result_vld_o);

  // R8
  timeout_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_err_o) |-> adc_cnv_n_o && !result_vld_o);

  // R9
  acq_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_cnv_n_o) |-> since_vld >= T_ACQ);

endmodule

bind adc_conv_seq adc_conv_seq_chk #(
  .SEL_START(SEL_START), .T_SETUP(T_SETUP), .T_PULSE(T_PULSE),
  .T_RC_MAX(T_RC_MAX), .T_ACQ(T_ACQ)
) u_chk (
  .clk(clk), .rst_n(rst_n), .adc_sel_n_o(adc_sel_n_o), .adc_cnv_n_o(adc_cnv_n_o),
  .adc_idle_i(adc_idle_i), .result_vld_o(result_vld_o),
  .timeout_err_o(timeout_err_o), .capture_evt(capture_evt)
);

// File: tb/sim_adc_conv_seq.sv
`timescale 1ns/1ps

// Converter stand-in that also records line timing seen at falling clock edges.
module adc_stub (
  input  logic        clk,
  input  logic        sel_n,
  input  logic        cnv_n,
  input  logic        vld,
  input  logic [15:0] res,
  output logic        idle,
  output logic [15:0] data
);
  int conv_len = 40;
  logic [15:0] next_val = 16'h0000;
  int cyc = 0, cnt = 0, run = 0, pre = 0, both = 0;
  int last_run = 0, last_pre = 0, last_both = 0, convs = 0;
  int vlds = 0, vld_run = 0, last_vld_len = 0, rise_at = 0, vld_at = 0, rcfall_at = 0;
  logic [15:0] out_reg = 16'h0000, last_res = 16'h0000;
  logic prev_both = 1'b0, prev_cnv = 1'b1, idle_q = 1'b1;

  assign idle = idle_q;
  assign data = cnv_n ? out_reg : 16'hBAD0;

  always @(negedge clk) begin
    cyc++;
    if (!cnv_n) begin
      run++;
      if (sel_n) pre++; else both++;
      if (prev_cnv) rcfall_at = cyc;
    end else if (run > 0) begin
      last_run = run; last_pre = pre; last_both = both;
      run = 0; pre = 0; both = 0;
    end
    if (!sel_n && !cnv_n && !prev_both) begin
      convs++;
      if (idle_q) begin idle_q = 1'b0; cnt = conv_len; end
    end else if (!idle_q) begin
      cnt--;
      if (cnt <= 0) begin idle_q = 1'b1; out_reg = next_val; rise_at = cyc; end
    end
    if (vld) begin
      vld_run++;
      if (vld_run == 1) begin vlds++; vld_at = cyc; last_res = res; end
    end else begin
      if (vld_run > 0) last_vld_len = vld_run;
      vld_run = 0;
    end
    prev_both = !sel_n && !cnv_n;
    prev_cnv  = cnv_n;
  end
endmodule

module sim_adc_conv_seq;
  localparam int TS = 2, TP = 8, TRC = 600, TTO = 2000, TACQ = 200;

  logic clk = 1'b0, rst_n = 1'b0, start0 = 1'b0, start1 = 1'b0;
  wire sel0, cnv0, vld0, err0, idle0, sel1, cnv1, vld1, err1, idle1;
  wire [15:0] d0, res0, d1, res1;
  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  adc_conv_seq #(.SEL_START(0), .DATA_W(16), .T_SETUP(TS), .T_PULSE(TP),
    .T_RC_MAX(TRC), .T_TIMEOUT(TTO), .T_ACQ(TACQ)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start0), .adc_idle_i(idle0), .adc_data_i(d0),
    .adc_sel_n_o(sel0), .adc_cnv_n_o(cnv0), .result_o(res0), .result_vld_o(vld0),
    .timeout_err_o(err0));

  adc_conv_seq #(.SEL_START(1), .DATA_W(16), .T_SETUP(TS), .T_PULSE(TP),
    .T_RC_MAX(TRC), .T_TIMEOUT(TTO), .T_ACQ(TACQ)) u1 (
    .clk(clk), .rst_n(rst_n), .start_i(start1), .adc_idle_i(idle1), .adc_data_i(d1),
    .adc_sel_n_o(sel1), .adc_cnv_n_o(cnv1), .result_o(res1), .result_vld_o(vld1),
    .timeout_err_o(err1));

  adc_stub m0 (.clk(clk), .sel_n(sel0), .cnv_n(cnv0), .vld(vld0), .res(res0),
               .idle(idle0), .data(d0));
  adc_stub m1 (.clk(clk), .sel_n(sel1), .cnv_n(cnv1), .vld(vld1), .res(res1),
               .idle(idle1), .data(d1));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  endtask

  task automatic wait_vld0(input int target);
    for (int i = 0; i < 6000; i++) begin
      if (m0.vlds >= target) break;
      @(negedge clk);
    end
  endtask

  task automatic wait_vld1(input int target);
    for (int i = 0; i < 6000; i++) begin
      if (m1.vlds >= target) break;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(cnv0 && !sel0 && !vld0 && !err0 && res0 == 16'h0, "R1 strobe-start idle",
        {cnv0, sel0, vld0, err0}, 4'b1000);
    chk(cnv1 && sel1 && !vld1 && !err1 && res1 == 16'h0, "R1 select-start idle",
        {cnv1, sel1, vld1, err1}, 4'b1100);
  endtask

  task automatic t_strobe_basic(input logic [15:0] val);
    int base;
    m0.conv_len = 40; m0.next_val = val; base = m0.vlds;
    @(negedge clk) start0 = 1'b1;
    @(negedge clk) start0 = 1'b0;
    chk(!cnv0 && !sel0, "R2 pulse starts next cycle", {cnv0, sel0}, 0);
    wait_vld0(base + 1);
    repeat (3) @(negedge clk);
    chk(m0.last_run == TP, "R2 pulse width", m0.last_run, TP);
    chk(m0.last_pre == 0, "R2 select held low", m0.last_pre, 0);
    chk(m0.last_run <= TRC, "R4 strobe low ceiling", m0.last_run, TRC);
    chk(m0.vld_at - m0.rise_at == TP + 1, "R6 read window latency",
        m0.vld_at - m0.rise_at, TP + 1);
    chk(m0.last_res == val, "R7 result value", 32'(m0.last_res), 32'(val));
    chk(m0.last_vld_len == 1, "R7 strobe length", m0.last_vld_len, 1);
    repeat (TACQ + 5) @(negedge clk);
  endtask

  task automatic t_select_conv(input logic [15:0] val);
    int base;
    m1.conv_len = 60; m1.next_val = val; base = m1.vlds;
    @(negedge clk) start1 = 1'b1;
    @(negedge clk) start1 = 1'b0;
    chk(!cnv1 && sel1, "R3 setup phase first", {cnv1, sel1}, 2'b01);
    wait_vld1(base + 1);
    repeat (3) @(negedge clk);
    chk(m1.last_pre == TS, "R3 setup length", m1.last_pre, TS);
    chk(m1.last_both == TP, "R3 overlap length", m1.last_both, TP);
    chk(m1.vld_at - m1.rise_at == TP + 1, "R6 read latency select mode",
        m1.vld_at - m1.rise_at, TP + 1);
    chk(m1.last_res == val, "R7 result select mode", 32'(m1.last_res), 32'(val));
    chk(m1.last_vld_len == 1, "R7 strobe length select mode", m1.last_vld_len, 1);
    repeat (TACQ + 5) @(negedge clk);
    chk(cnv1 && sel1, "R3 lines back high", {cnv1, sel1}, 2'b11);
  endtask

  task automatic t_ignore_and_acq;
    int base, c;
    m0.conv_len = 200; m0.next_val = 16'h0F0F; base = m0.vlds; c = m0.convs;
    @(negedge clk) start0 = 1'b1;
    wait_vld0(base + 1);
    chk(m0.convs == c + 1, "R5 start ignored during conversion", m0.convs, c + 1);
    for (int i = 0; i < 1000; i++) begin
      if (m0.convs >= c + 2) break;
      @(negedge clk);
    end
    start0 = 1'b0;
    chk(m0.rcfall_at - m0.vld_at == TACQ + 1, "R9 acquisition gap",
        m0.rcfall_at - m0.vld_at, TACQ + 1);
    wait_vld0(base + 2);
    repeat (3) @(negedge clk);
    chk(m0.convs == c + 2, "R5 no extra pulse", m0.convs, c + 2);
    chk(m0.last_res == 16'h0F0F, "R7 second result", 32'(m0.last_res), 32'h0F0F);
    repeat (TACQ + 5) @(negedge clk);
  endtask

  task automatic t_timeout;
    int base, c, k;
    m0.conv_len = 3000; m0.next_val = 16'h5555; base = m0.vlds;
    @(negedge clk) start0 = 1'b1;
    @(negedge clk) start0 = 1'b0;
    k = 1;
    while (!err0 && k < 3000) begin
      @(negedge clk);
      k++;
    end
    chk(k == TTO + 1, "R8 timeout cycle", k, TTO + 1);
    chk(m0.vlds == base, "R8 no result on timeout", m0.vlds, base);
    chk(cnv0 && !sel0, "R8 back to idle levels", {cnv0, sel0}, 2'b10);
    c = m0.convs;
    start0 = 1'b1;
    repeat (50) @(negedge clk);
    start0 = 1'b0;
    chk(m0.convs == c && err0, "R5 start ignored while converter busy", m0.convs, c);
    for (int i = 0; i < 2000; i++) begin
      if (idle0) break;
      @(negedge clk);
    end
    m0.conv_len = 40; m0.next_val = 16'h7E81;
    @(negedge clk) start0 = 1'b1;
    @(negedge clk) start0 = 1'b0;
    chk(!err0, "R8 flag cleared by new start", err0, 0);
    wait_vld0(base + 1);
    repeat (3) @(negedge clk);
    chk(m0.last_res == 16'h7E81, "R8 recovery result", 32'(m0.last_res), 32'h7E81);
    repeat (TACQ + 5) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_strobe_basic(16'h1234);
    t_strobe_basic(16'hFFFF);
    t_select_conv(16'hA5C3);
    t_select_conv(16'h0000);
    t_ignore_and_acq;
    t_timeout;
    finish_run;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog all requirements act=hung exp=finished");
    finish_run;
  end

endmodule